// File: doc/BRIEF.md
# Shared SIMD / Floating-Point Register State Tracker

This block holds the architectural state that two instruction classes share: a file of eight 80-bit physical registers, a 16-bit tag word made of eight 2-bit tags, and a 3-bit top-of-stack pointer. The stack-based floating-point unit commits its own tag and top-of-stack updates through the block. The packed 64-bit SIMD unit reaches the same registers by absolute index. The block applies the side effects that each class has on the shared state.

A SIMD operation resets the stack view: top-of-stack goes to zero and every tag becomes valid. A SIMD register write fills the upper 16 bits of the target register with ones. A separate clear-state operation marks every tag empty. When the emulation control bit is set, any SIMD-class strobe is refused. In that case the block raises a one-cycle invalid-opcode pulse and leaves all state untouched. Floating-point arithmetic is not part of this block.

Top module: `simd_fpu_alias_state`

## Requirements
- R1: After reset, tag_word is 16'hFFFF (every 2-bit tag is 11b = empty), tos is 0, every physical register reads 0, and ill_op is 0.
- R2: A SIMD strobe (simd_op=1, empty_op=0, emul_en=0) sets tos to 0 and tag_word to 16'h0000 (every tag 00b = valid) on the next cycle, whatever their previous values.
- R3: A SIMD strobe with simd_wr=1 writes physical register simd_idx so that bits 63:0 hold simd_wdata and bits 79:64 hold 16'hFFFF. The index is absolute and does not depend on tos. Other registers are unchanged.
- R4: A clear-state strobe (empty_op=1, emul_en=0) sets tag_word to 16'hFFFF and changes neither tos nor any register.
- R5: When emul_en=1, a strobe on simd_op or empty_op makes ill_op 1 for exactly the following cycle. It leaves tags, tos and registers unchanged. ill_op is 0 in every other cycle.
- R6: A floating-point commit (fp_op=1 with simd_op=0 and empty_op=0) loads tag_word from fp_tags and tos from fp_tos unmodified. With no strobe at all, the state holds.
- R7: Strobe priority is empty_op over simd_op over fp_op. A lower strobe asserted together with a higher one has no effect.
- R8: rd_data returns physical register rd_idx one cycle after rd_idx is presented, as it stood before that cycle's write. rd_simd is bits 63:0 of the same value.
- R9: simd_wr without an accepted SIMD strobe writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| simd_op | input | 1 | SIMD instruction strobe |
| simd_wr | input | 1 | The SIMD instruction writes a register |
| simd_idx | input | 3 | SIMD destination register index |
| simd_wdata | input | 64 | SIMD write data |
| empty_op | input | 1 | Clear-state (mark all tags empty) strobe |
| emul_en | input | 1 | Emulation control; 1 makes SIMD-class strobes fault |
| fp_op | input | 1 | Floating-point state commit strobe |
| fp_tags | input | 16 | Tag word committed by the floating-point unit |
| fp_tos | input | 3 | Top-of-stack committed by the floating-point unit |
| rd_idx | input | 3 | Physical register read index |
| rd_data | output | 80 | Registered full-width read data |
| rd_simd | output | 64 | Registered SIMD view (bits 63:0) |
| tag_word | output | 16 | Current tag word |
| tos | output | 3 | Current top-of-stack |
| ill_op | output | 1 | Invalid-opcode pulse |

## Verification
The bound checker tests the tag and top-of-stack effects of each accepted strobe, the fault pulse and its state freeze, the verbatim floating-point commit and the hold on idle cycles, on every cycle. The register contents are checked only by the bench. It sweeps every strobe combination against every write index and a range of prior top-of-stack values, then reads all eight registers back. This is the only way to show that a faulted, lower-priority or stray write left the register file alone and that SIMD indexing ignores the stack pointer.

// File: rtl/alias_state_pkg.sv
package alias_state_pkg;
  localparam int unsigned NREG    = 8;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned EXT_W   = 16;
  localparam int unsigned TAG_W   = 2;
  localparam int unsigned REG_W   = DATA_W + EXT_W;
  localparam int unsigned IDX_W   = $clog2(NREG);
  localparam int unsigned TWORD_W = NREG * TAG_W;

  localparam logic [TAG_W-1:0] TAG_VALID = 2'b00;
  localparam logic [TAG_W-1:0] TAG_EMPTY = 2'b11;

  typedef struct packed {
    logic clr;
    logic simd;
    logic wr;
    logic fp;
    logic fault;
  } alias_act_t;
endpackage

// File: rtl/alias_cmd_decode.sv
module alias_cmd_decode
  import alias_state_pkg::*;
(
  input  logic       empty_op,
  input  logic       simd_op,
  input  logic       simd_wr,
  input  logic       fp_op,
  input  logic       emul_en,
  output alias_act_t act
);
  logic simd_class;

  always_comb begin
    simd_class = empty_op | simd_op;
    act.fault  = simd_class & emul_en;
    act.clr    = empty_op & ~emul_en;
    act.simd   = simd_op & ~empty_op & ~emul_en;
    act.wr     = act.simd & simd_wr;
    act.fp     = fp_op & ~simd_class;
  end
endmodule

// File: rtl/alias_tag_tos.sv
module alias_tag_tos
  import alias_state_pkg::*;
#(
  parameter int unsigned N_TAGS = NREG,
  parameter int unsigned TW     = TAG_W,
  parameter int unsigned PTR_W  = $clog2(N_TAGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  alias_act_t           act,
  input  logic [N_TAGS*TW-1:0] fp_tags,
  input  logic [PTR_W-1:0]     fp_tos,
  output logic [N_TAGS*TW-1:0] tag_word,
  output logic [PTR_W-1:0]     tos
);
  for (genvar g = 0; g < N_TAGS; g++) begin : g_tag
    logic [TW-1:0] tag_q;
    always_ff @(posedge clk) begin
      if (rst)           tag_q <= TAG_EMPTY;
      else if (act.clr)  tag_q <= TAG_EMPTY;
      else if (act.simd) tag_q <= TAG_VALID;
      else if (act.fp)   tag_q <= fp_tags[g*TW +: TW];
    end
    assign tag_word[g*TW +: TW] = tag_q;
  end

  always_ff @(posedge clk) begin
    if (rst)           tos <= '0;
    else if (act.simd) tos <= '0;
    else if (act.fp && !act.clr) tos <= fp_tos;
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile
  import alias_state_pkg::*;
#(
  parameter int unsigned DEPTH = NREG,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned XW    = EXT_W,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned RW    = DW + XW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [RW-1:0] rdata
);
  logic [RW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= {{XW{1'b1}}, wdata};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/simd_fpu_alias_state.sv
module simd_fpu_alias_state
  import alias_state_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               simd_op,
  input  logic               simd_wr,
  input  logic [IDX_W-1:0]   simd_idx,
  input  logic [DATA_W-1:0]  simd_wdata,
  input  logic               empty_op,
  input  logic               emul_en,
  input  logic               fp_op,
  input  logic [TWORD_W-1:0] fp_tags,
  input  logic [IDX_W-1:0]   fp_tos,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [REG_W-1:0]   rd_data,
  output logic [DATA_W-1:0]  rd_simd,
  output logic [TWORD_W-1:0] tag_word,
  output logic [IDX_W-1:0]   tos,
  output logic               ill_op
);
  alias_act_t act;

  alias_cmd_decode u_dec (
    .empty_op (empty_op),
    .simd_op  (simd_op),
    .simd_wr  (simd_wr),
    .fp_op    (fp_op),
    .emul_en  (emul_en),
    .act      (act)
  );

  alias_tag_tos u_tt (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .fp_tags  (fp_tags),
    .fp_tos   (fp_tos),
    .tag_word (tag_word),
    .tos      (tos)
  );

  alias_regfile u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (act.wr),
    .waddr (simd_idx),
    .wdata (simd_wdata),
    .raddr (rd_idx),
    .rdata (rd_data)
  );

  assign rd_simd = rd_data[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) ill_op <= 1'b0;
    else     ill_op <= act.fault;
  end
endmodule

// File: rtl/simd_fpu_alias_state_chk.sv
module simd_fpu_alias_state_chk
  import alias_state_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               simd_op,
  input logic               empty_op,
  input logic               emul_en,
  input logic               fp_op,
  input logic [TWORD_W-1:0] fp_tags,
  input logic [IDX_W-1:0]   fp_tos,
  input logic [TWORD_W-1:0] tag_word,
  input logic [IDX_W-1:0]   tos,
  input logic               ill_op
);
  logic any_fault;
  assign any_fault = (simd_op | empty_op) & emul_en;

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (tag_word == '1 && tos == '0 && !ill_op));

  p_simd_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (simd_op && !empty_op && !emul_en) |=> (tag_word == '0 && tos == '0));

  p_empty_marks_r4: assert property (@(posedge clk) disable iff (rst)
    (empty_op && !emul_en) |=> (tag_word == '1 && $stable(tos)));

  p_fault_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    any_fault |=> (ill_op && $stable(tag_word) && $stable(tos)));

  p_no_stray_fault_r5: assert property (@(posedge clk) disable iff (rst)
    !any_fault |=> !ill_op);

  p_fp_commit_r6: assert property (@(posedge clk) disable iff (rst)
    (fp_op && !simd_op && !empty_op) |=>
      (tag_word == $past(fp_tags) && tos == $past(fp_tos)));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!fp_op && !simd_op && !empty_op) |=> ($stable(tag_word) && $stable(tos)));
endmodule

bind simd_fpu_alias_state simd_fpu_alias_state_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .simd_op  (simd_op),
  .empty_op (empty_op),
  .emul_en  (emul_en),
  .fp_op    (fp_op),
  .fp_tags  (fp_tags),
  .fp_tos   (fp_tos),
  .tag_word (tag_word),
  .tos      (tos),
  .ill_op   (ill_op)
);

// File: tb/simd_fpu_alias_state_bench.sv
module simd_fpu_alias_state_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        simd_op, simd_wr, empty_op, emul_en, fp_op;
  logic [2:0]  simd_idx, fp_tos, rd_idx;
  logic [63:0] simd_wdata;
  logic [15:0] fp_tags;
  logic [79:0] rd_data;
  logic [63:0] rd_simd;
  logic [15:0] tag_word;
  logic [2:0]  tos;
  logic        ill_op;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] m_tags;
  logic [2:0]  m_tos;
  logic [79:0] m_reg [8];
  logic        m_ill;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_fpu_alias_state u_simd_fpu_alias_state (
    .clk(clk), .rst(rst), .simd_op(simd_op), .simd_wr(simd_wr),
    .simd_idx(simd_idx), .simd_wdata(simd_wdata), .empty_op(empty_op),
    .emul_en(emul_en), .fp_op(fp_op), .fp_tags(fp_tags), .fp_tos(fp_tos),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_simd(rd_simd),
    .tag_word(tag_word), .tos(tos), .ill_op(ill_op)
  );

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    simd_op = 0; simd_wr = 0; empty_op = 0; emul_en = 0; fp_op = 0;
    simd_idx = 0; simd_wdata = 0; fp_tags = 0; fp_tos = 0;
  endtask

  // One cycle of stimulus; model follows R2..R7, R9.
  task automatic step(input logic e, input logic s, input logic w, input logic f,
                      input logic em, input logic [2:0] ix, input logic [63:0] d,
                      input logic [15:0] ft, input logic [2:0] fs, input string req);
    @(negedge clk);
    empty_op = e; simd_op = s; simd_wr = w; fp_op = f; emul_en = em;
    simd_idx = ix; simd_wdata = d; fp_tags = ft; fp_tos = fs;
    @(posedge clk);
    m_ill = (e | s) & em;
    if (!em && e) m_tags = 16'hFFFF;
    else if (!em && s) begin
      m_tags = 16'h0000; m_tos = 3'd0;
      if (w) m_reg[ix] = {16'hFFFF, d};
    end else if (!(e | s) && f) begin
      m_tags = ft; m_tos = fs;
    end
    @(negedge clk);
    idle_inputs();
    check({req, " tags"}, 80'(tag_word), 80'(m_tags));
    check({req, " tos"}, 80'(tos), 80'(m_tos));
    check({req, " ill_op"}, 80'(ill_op), 80'(m_ill));
  endtask

  // R8: registered read of every physical register.
  task automatic read_all(input string req);
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      rd_idx = 3'(r);
      @(negedge clk);
      check({req, " R8 rd_data"}, rd_data, m_reg[r]);
      check({req, " R8 rd_simd"}, 80'(rd_simd), 80'(m_reg[r][63:0]));
    end
  endtask

  initial begin
    idle_inputs();
    rd_idx = 0;
    rst = 1;
    for (int r = 0; r < 8; r++) m_reg[r] = '0;
    m_tags = 16'hFFFF; m_tos = 0; m_ill = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 tags", 80'(tag_word), 80'hFFFF);
    check("R1 tos", 80'(tos), 80'h0);
    check("R1 ill_op", 80'(ill_op), 80'h0);
    read_all("R1");

    // R3: absolute index under every prior top-of-stack value.
    for (int t = 0; t < 8; t++) begin
      for (int ix = 0; ix < 8; ix++) begin
        step(0, 0, 0, 1, 0, 0, 0, 16'(16'h1234 * (t + 1)), 3'(t), "R6 fp commit");
        step(0, 1, 1, 0, 0, 3'(ix),
             {8'(t), 8'(ix), 48'hC0DE_0000_0000 + 48'(t * 97 + ix)}, 0, 0, "R2 R3 simd write");
      end
      read_all("R3");
    end

    // R4: empty after arbitrary fp state keeps tos.
    step(0, 0, 0, 1, 0, 0, 0, 16'h5A3C, 3'd5, "R6 fp commit");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R4 empty");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 idle hold");

    // R5 R7 R9: every strobe combination with a write request.
    for (int c = 0; c < 32; c++) begin
      step(0, 0, 0, 1, 0, 0, 0, 16'h0F0F ^ 16'(c * 521), 3'(c + 3), "R6 fp setup");
      step(c[0], c[1], c[2], c[3], c[4], 3'(c), {32'hBEEF_0000, 32'(c)},
           16'h9669 ^ 16'(c), 3'(c), "R5 R7 R9 combo");
      check("R5 ill_op clears", 80'(ill_op), 80'(m_ill));
      @(negedge clk);
      check("R5 single pulse", 80'(ill_op), 80'h0);
      if (c[4:0] == 5'b10110 || c[2:0] == 3'b101) read_all("R5 R7 R9");
    end
    read_all("R7 R9 final");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule